// File: doc/BRIEF.md
# PS/2 Device-Side Byte Transmitter

This block sends single bytes from a pointing device to a host over the two-wire PS/2 link. The device generates the clock. Both wires are open-collector. The block only ever pulls a wire low or lets it go. It never drives a wire high. Upstream logic hands over a byte with a valid/ready handshake. The block holds that byte until it is delivered, and builds an 11-bit frame from it: a low start bit, the data bits with the least significant bit first, an odd parity bit, and a high stop bit.

The block starts a frame only after both wires have been sampled high without a break for a set number of system clocks. If the host holds the clock wire low, the host is blocking the device. If the host keeps the clock high but pulls the data wire low, the host wants to send. In both cases the block waits.

Once a frame is running, the block samples the clock wire at the end of each released half-period. If the host has pulled the clock wire low before the device's tenth clock has risen, the block does three things:
- it lets both wires go;
- it pulses an abort flag;
- it keeps the byte and sends it again once the bus has been idle long enough.

If the host pulls the clock low after the tenth clock, the frame is already delivered. The block finishes it and pulses done.

Top module: `ps2_dev_tx`

## Requirements
- R1: After reset, both pull-down enables are off, `tx_ready` is high, and `tx_done` and `tx_abort` are low. Whenever `tx_ready` is high, neither wire is pulled.
- R2: A frame is 11 bits, each read while the device holds the clock low, in this order:
  - bit 0 is the start bit, 0;
  - bits 1 to 8 are the data byte, least significant bit first;
  - bit 9 is the parity bit, chosen so that the data and parity together hold an odd number of ones;
  - bit 10 is the stop bit, 1.
- R3: While the clock wire is held low by the host, no frame starts, and neither wire is pulled.
- R4: While the clock wire is high and the data wire is held low by the host, no frame starts, and neither wire is pulled.
- R5: A frame starts only after both wires have been sampled high for IDLE_CYC consecutive cycles. An idle stretch that is shorter than this and then broken does not start a frame.
- R6: The data pull enable never changes in a cycle where the clock pull enable rises or falls. It also never changes while the clock pull stays on.
- R7: Each clock low phase lasts exactly HALF_CYC system cycles.
- R8: If the host has pulled the clock low before the rising edge of the tenth device clock, the frame is aborted:
  - both wires are released;
  - `tx_abort` pulses for one cycle;
  - `tx_ready` stays low, because the byte is kept.
- R9: If the host pulls the clock low only after the tenth device clock has risen, the frame is not aborted. It runs through all 11 clocks, and `tx_done` pulses in the cycle where the last clock is released.
- R10: An aborted byte is sent again, complete and unchanged, once the bus has been idle as R5 requires.
- R11: `tx_done` is a one-cycle pulse. `tx_ready` returns high in the same cycle, and a new byte is taken only when `tx_valid` and `tx_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Block can take a byte |
| line_clk_in | input | 1 | Sampled level of the PS/2 clock wire |
| line_dat_in | input | 1 | Sampled level of the PS/2 data wire |
| clk_pull | output | 1 | 1 pulls the clock wire low; 0 releases it |
| dat_pull | output | 1 | 1 pulls the data wire low; 0 releases it |
| tx_done | output | 1 | One-cycle pulse: frame delivered |
| tx_abort | output | 1 | One-cycle pulse: frame aborted by host contention |

## Verification
At the end of each released clock phase, two decisions fall on the same cycle: whether the host has contended, and whether the frame moves on toward completion. The outcome depends on whether that phase comes before the tenth clock or after it. The bench provokes this by pulling the clock low from the host side in two places. The first is just after the ninth device clock rises, which must give an abort with the byte kept and sent again later. The second is just after the tenth device clock rises, which must give a full, correct frame with a done pulse and no abort. The bench counts the abort and done pulses, and a scoreboard matches every completed frame against the queue of bytes that were offered.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_t;

  localparam int FRAME_EXTRA = 3;

  function automatic int frame_width(input int data_w);
    return data_w + FRAME_EXTRA;
  endfunction
endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] synced
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] shreg;
    always_ff @(posedge clk) begin
      if (rst) begin
        shreg <= '1;
      end else begin
        shreg <= {shreg[STAGES-2:0], raw[g]};
      end
    end
    assign synced[g] = shreg[STAGES-1];
  end
endmodule

// File: rtl/ps2_frame_pack.sv
module ps2_frame_pack #(
  parameter int DATA_W  = 8,
  localparam int FRM_W  = DATA_W + 3
) (
  input  logic [DATA_W-1:0] payload,
  output logic [FRM_W-1:0]  frame
);
  logic odd_bit;
  always_comb begin
    odd_bit = ~(^payload);
    frame   = {1'b1, odd_bit, payload, 1'b0};
  end
endmodule

// File: rtl/ps2_half_timer.sv
module ps2_half_timer #(
  parameter int HALF_CYC = 4000,
  localparam int CNT_W   = $clog2(HALF_CYC)
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic at_mid,
  output logic at_last
);
  localparam logic [CNT_W-1:0] MID_VAL  = CNT_W'(HALF_CYC / 2);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign at_mid  = (cnt == MID_VAL);
  assign at_last = (cnt == LAST_VAL);
endmodule

// File: rtl/ps2_idle_watch.sv
module ps2_idle_watch #(
  parameter int IDLE_CYC = 5000,
  localparam int IW      = $clog2(IDLE_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic clk_hi,
  input  logic dat_hi,
  output logic bus_idle
);
  localparam logic [IW-1:0] FULL = IW'(IDLE_CYC);

  logic [IW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst || !armed || !(clk_hi && dat_hi)) begin
      run <= '0;
    end else if (run != FULL) begin
      run <= run + 1'b1;
    end
  end

  assign bus_idle = (run == FULL);
endmodule

// File: rtl/ps2_dev_tx.sv
module ps2_dev_tx
  import ps2tx_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int HALF_CYC     = 4000,
  parameter int IDLE_CYC     = 5000,
  parameter int SYNC_STAGES  = 2,
  parameter int GUARD_CLOCKS = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              line_clk_in,
  input  logic              line_dat_in,
  output logic              clk_pull,
  output logic              dat_pull,
  output logic              tx_done,
  output logic              tx_abort
);
  localparam int FRM_W = frame_width(DATA_W);
  localparam int IDX_W = $clog2(FRM_W);
  localparam logic [IDX_W-1:0] GUARD_IDX = IDX_W'(GUARD_CLOCKS);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRM_W - 1);

  phase_t            phase;
  logic [IDX_W-1:0]  idx;
  logic [FRM_W-1:0]  frame_q;
  logic [FRM_W-1:0]  frame_w;
  logic [DATA_W-1:0] hold_q;
  logic              have_q;
  logic [1:0]        line_s;
  logic              clk_s;
  logic              dat_s;
  logic              bus_idle;
  logic              t_mid;
  logic              t_last;

  ps2_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw    ({line_dat_in, line_clk_in}),
    .synced (line_s)
  );
  assign clk_s = line_s[0];
  assign dat_s = line_s[1];

  ps2_idle_watch #(.IDLE_CYC(IDLE_CYC)) u_idle (
    .clk      (clk),
    .rst      (rst),
    .armed    (phase == PH_IDLE),
    .clk_hi   (clk_s),
    .dat_hi   (dat_s),
    .bus_idle (bus_idle)
  );

  ps2_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart ((phase == PH_IDLE) || t_last),
    .at_mid  (t_mid),
    .at_last (t_last)
  );

  ps2_frame_pack #(.DATA_W(DATA_W)) u_pack (
    .payload (hold_q),
    .frame   (frame_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      idx      <= '0;
      frame_q  <= '0;
      hold_q   <= '0;
      have_q   <= 1'b0;
      tx_ready <= 1'b1;
      clk_pull <= 1'b0;
      dat_pull <= 1'b0;
      tx_done  <= 1'b0;
      tx_abort <= 1'b0;
    end else begin
      tx_done  <= 1'b0;
      tx_abort <= 1'b0;
      if (tx_ready && tx_valid) begin
        hold_q   <= tx_data;
        have_q   <= 1'b1;
        tx_ready <= 1'b0;
      end
      case (phase)
        PH_IDLE: begin
          clk_pull <= 1'b0;
          dat_pull <= 1'b0;
          if (have_q && bus_idle) begin
            phase   <= PH_HIGH;
            idx     <= '0;
            frame_q <= frame_w;
          end
        end
        PH_HIGH: begin
          if (t_mid) begin
            dat_pull <= ~frame_q[idx];
          end
          if (t_last) begin
            if ((idx < GUARD_IDX) && !clk_s) begin
              phase    <= PH_IDLE;
              clk_pull <= 1'b0;
              dat_pull <= 1'b0;
              tx_abort <= 1'b1;
            end else begin
              phase    <= PH_LOW;
              clk_pull <= 1'b1;
            end
          end
        end
        PH_LOW: begin
          if (t_last) begin
            clk_pull <= 1'b0;
            if (idx == LAST_IDX) begin
              phase    <= PH_IDLE;
              dat_pull <= 1'b0;
              tx_done  <= 1'b1;
              have_q   <= 1'b0;
              tx_ready <= 1'b1;
            end else begin
              phase <= PH_HIGH;
              idx   <= idx + 1'b1;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ps2_dev_tx_chk.sv
module ps2_dev_tx_chk (
  input logic clk,
  input logic rst,
  input logic clk_pull,
  input logic dat_pull,
  input logic tx_ready,
  input logic tx_done,
  input logic tx_abort
);
  AST_READY_LINES_FREE: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> (!clk_pull && !dat_pull)); // R1
  AST_DATA_STEADY_LOW: assert property (@(posedge clk) disable iff (rst)
    (clk_pull && $past(clk_pull)) |-> $stable(dat_pull)); // R6
  AST_DATA_STEADY_EDGE: assert property (@(posedge clk) disable iff (rst)
    ($rose(clk_pull) || $fell(clk_pull)) |-> $stable(dat_pull)); // R6
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    tx_abort |-> (!clk_pull && !dat_pull)); // R8
  AST_ABORT_KEEPS_BYTE: assert property (@(posedge clk) disable iff (rst)
    tx_abort |-> !tx_ready); // R8
  AST_DONE_NOT_ABORT: assert property (@(posedge clk) disable iff (rst)
    !(tx_done && tx_abort)); // R9
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> $fell(clk_pull)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done); // R11
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> tx_ready); // R11
endmodule

bind ps2_dev_tx ps2_dev_tx_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .clk_pull (clk_pull),
  .dat_pull (dat_pull),
  .tx_ready (tx_ready),
  .tx_done  (tx_done),
  .tx_abort (tx_abort)
);

// File: tb/ps2_dev_tx_tb.sv
`timescale 1ns/1ps
module ps2_dev_tx_tb;
  localparam int HALF = 8;
  localparam int IDLE = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_ready, clk_pull, dat_pull, tx_done, tx_abort;
  logic host_clk_pull = 1'b0;
  logic host_dat_pull = 1'b0;
  logic bus_clk, bus_dat;

  assign bus_clk = ~(clk_pull | host_clk_pull);
  assign bus_dat = ~(dat_pull | host_dat_pull);

  always #5 clk = ~clk;

  ps2_dev_tx #(.DATA_W(8), .HALF_CYC(HALF), .IDLE_CYC(IDLE), .SYNC_STAGES(2), .GUARD_CLOCKS(10)) u_dut (
    .clk(clk), .rst(rst), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .line_clk_in(bus_clk), .line_dat_in(bus_dat), .clk_pull(clk_pull), .dat_pull(dat_pull),
    .tx_done(tx_done), .tx_abort(tx_abort)
  );

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q[$];
  int mon_bits = 0;
  logic [10:0] mon_frm = '0;
  logic prev_pull = 1'b0;
  int low_len = 0;
  int done_cnt = 0;
  int abort_cnt = 0;
  logic saw_pull = 1'b0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor and scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (clk_pull || dat_pull) saw_pull = 1'b1;
      if (tx_done) done_cnt++;
      if (tx_abort) begin
        abort_cnt++;
        mon_bits = 0;
      end
      if (clk_pull && !prev_pull) begin
        mon_frm[mon_bits] = bus_dat;
        mon_bits++;
        low_len = 1;
      end else if (clk_pull) begin
        low_len++;
      end
      if (!clk_pull && prev_pull)
        check(low_len == HALF, "R7 low phase length", low_len, HALF);
      if (mon_bits == 11) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected frame", mon_frm, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(mon_frm[0] == 1'b0, "R2 start bit", mon_frm[0], 0);
          check(mon_frm[8:1] == e, "R2 data bits LSB first", mon_frm[8:1], e);
          check(mon_frm[9] == ~(^e), "R2 odd parity", mon_frm[9], ~(^e));
          check(mon_frm[10] == 1'b1, "R2 stop bit", mon_frm[10], 1);
        end
        mon_bits = 0;
      end
      prev_pull = clk_pull;
    end
  end

  task automatic send(input logic [7:0] b);
    while (!tx_ready) @(negedge clk);
    tx_data = b;
    tx_valid = 1'b1;
    exp_q.push_back(b);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || !tx_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_bits(input int n);
    while (mon_bits < n) @(negedge clk);
    while (clk_pull) @(negedge clk);
  endtask

  task automatic host_pulse_clk(input int cyc);
    host_clk_pull = 1'b1;
    repeat (cyc) @(negedge clk);
    host_clk_pull = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int exp_done;
    int t;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!clk_pull && !dat_pull, "R1 lines released", {clk_pull, dat_pull}, 0);
    check(tx_ready, "R1 ready after reset", tx_ready, 1);
    check(!tx_done && !tx_abort, "R1 no status", {tx_done, tx_abort}, 0);

    // R2 normal frames, several patterns
    exp_done = 0;
    foreach (exp_done_pat[i]) begin end
    send(8'hA5); wait_idle(); exp_done++;
    send(8'h00); wait_idle(); exp_done++;
    send(8'hFF); wait_idle(); exp_done++;
    send(8'h01); send(8'h80); wait_idle(); exp_done += 2;
    check(done_cnt == exp_done, "R11 done pulse per frame", done_cnt, exp_done);
    check(abort_cnt == 0, "R2 no abort on clean frames", abort_cnt, 0);

    // R3 inhibit
    host_clk_pull = 1'b1;
    repeat (4) @(negedge clk);
    saw_pull = 1'b0;
    send(8'h3C);
    repeat (60) @(negedge clk);
    check(!saw_pull, "R3 no start while inhibited", saw_pull, 0);
    check(!tx_ready, "R11 byte held while waiting", tx_ready, 0);
    // R5 short idle stretch does not start
    host_clk_pull = 1'b0;
    repeat (IDLE - 2) @(negedge clk);
    host_clk_pull = 1'b1;
    repeat (30) @(negedge clk);
    check(!saw_pull, "R5 short idle ignored", saw_pull, 0);
    host_clk_pull = 1'b0;
    t = 0;
    while (!dat_pull) begin @(negedge clk); t++; end
    check(t >= IDLE && t <= IDLE + HALF + 4, "R5 start delay after idle", t, IDLE);
    wait_idle(); exp_done++;

    // R4 request-to-send
    host_dat_pull = 1'b1;
    repeat (4) @(negedge clk);
    saw_pull = 1'b0;
    send(8'h5A);
    repeat (60) @(negedge clk);
    check(!saw_pull, "R4 no start during host request", saw_pull, 0);
    host_dat_pull = 1'b0;
    wait_idle(); exp_done++;

    // R8 abort mid-frame, R10 retry
    send(8'hC3);
    wait_bits(4);
    host_pulse_clk(12);
    check(abort_cnt == 1, "R8 abort mid-frame", abort_cnt, 1);
    check(!tx_ready, "R8 byte kept after abort", tx_ready, 0);
    check(done_cnt == exp_done, "R8 no done on abort", done_cnt, exp_done);
    wait_idle(); exp_done++;
    check(done_cnt == exp_done, "R10 retried byte delivered", done_cnt, exp_done);

    // R8 boundary: contention before tenth clock
    send(8'h96);
    wait_bits(9);
    host_pulse_clk(12);
    check(abort_cnt == 2, "R8 abort before tenth clock", abort_cnt, 2);
    wait_idle(); exp_done++;
    check(done_cnt == exp_done, "R10 retry after late abort", done_cnt, exp_done);

    // R9 boundary: contention after tenth clock
    send(8'h69);
    wait_bits(10);
    host_pulse_clk(12);
    wait_idle(); exp_done++;
    check(abort_cnt == 2, "R9 no abort after tenth clock", abort_cnt, 2);
    check(done_cnt == exp_done, "R9 frame completes", done_cnt, exp_done);
    check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int exp_done_pat[1];
endmodule